// File: doc/BRIEF.md
# UART Receive Idle-Timeout Guard

This block ends a UART receive transfer when the line goes quiet. A tick counter runs at the base clock rate with no prescaler. The first received-byte strobe of a transfer arms the counter from zero, and every later byte strobe restarts it from zero. When the count reaches the programmed timeout without another byte, the block does three things at once: it emits a one-cycle stop-receive pulse, it sets a sticky idle-expired flag, and it clears and halts the counter. Until the next byte arrives, no further pulse can occur.

The timeout is not a fixed cycle count. It is derived from the baud register word, the same value that sets the receiver's bit rate, so it always spans roughly twenty bit periods. The block computes it as 2^31 divided by (baud word / 40). A small iterative divider does this on every baud write, and once after reset from a parameter default. While that reload runs, the count is forced to zero. An end-of-receive strobe, or dropping the enable, stops the counter outright.

Top module: `rxidle_guard`

## Requirements
- R1: After reset `stop_rx_pulse` and `idle_expired` are 0 and the counter is disarmed.
- R2: Within CNT_W cycles of a baud write (or of reset release), `timeout_ticks` equals floor(2^31 / floor(baud_word / 40)). It is all ones when baud_word is below 40. It holds that value until the next write.
- R3: Take a byte strobe sampled at clock edge k, with timeout T and no later strobe or reload. Then `stop_rx_pulse` is high for exactly one cycle, produced by edge k+T+1.
- R4: Every byte strobe restarts the count from zero, so the pulse comes T+1 edges after the last byte.
- R5: With no byte strobe since reset, the block never pulses, however long the line stays idle.
- R6: An end-of-receive strobe disarms and clears the counter, and no pulse follows until a new byte arrives.
- R7: While `guard_en` is 0 the counter is disarmed and byte strobes are ignored, so no pulse occurs.
- R8: `idle_expired` rises together with the stop pulse. It stays set until `flag_clr`, and a pulse in the same cycle wins over the clear.
- R9: A baud write clears the count and holds it at zero during the CNT_W-cycle reload. An armed counter then resumes, so with no further bytes the pulse comes CNT_W+T+1 edges after the write edge.
- R10: After the pulse the counter is halted, and no second pulse occurs without a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; the counter advances once per edge |
| rst | input | 1 | Synchronous active-high reset |
| guard_en | input | 1 | Enables the guard; 0 disarms it |
| rx_byte_stb | input | 1 | One-cycle strobe per received byte; arms and restarts |
| rx_done_stb | input | 1 | End-of-receive or read cancel; disarms |
| baud_wr | input | 1 | Loads `baud_word` and starts a timeout reload |
| baud_word | input | 32 | Baud register word used to derive the timeout |
| flag_clr | input | 1 | Clears the sticky idle flag |
| stop_rx_pulse | output | 1 | One-cycle stop-receive request |
| idle_expired | output | 1 | Sticky flag: a timeout has fired |
| timeout_ticks | output | 32 | Current timeout in base-clock ticks |

## Verification
The bench measures the exact edge of the stop pulse for several baud words. A counter off by one, or one that compares before incrementing, would pulse one cycle early or late. A byte landing just before expiry must push the pulse out by a full timeout; a design that does not restart would fire on the old schedule. The bench also waits long stretches with no byte, after an end strobe and while disabled, where a free-running counter would emit a spurious stop. It checks that a baud word below 40 saturates the timeout rather than dividing by zero. A reload in mid-count must delay the pulse by the reload length; a design that kept counting during the reload would fire early.

// File: rtl/rxidle_pkg.sv
package rxidle_pkg;
    // Counter arming state
    typedef enum logic {
        WD_IDLE  = 1'b0,
        WD_ARMED = 1'b1
    } wd_state_e;

    // The baud word is scaled down by this factor before it divides 2^31
    localparam int unsigned BAUD_SCALE = 40;

    // Iterative divider working state
    typedef struct packed {
        logic        busy;
        logic [31:0] rem;
    } div_core_t;
endpackage

// File: rtl/rxidle_div.sv
module rxidle_div #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic [W-1:0] quot
);
    localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

    logic         busy_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] dvs_q;
    logic [W-1:0] quot_q;
    logic [IW-1:0] idx_q;

    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;

    // Numerator is 2^(W-1): only its first (top) bit is one
    always_comb begin
        trial = {rem_q, (idx_q == LAST_IDX)};
        diff  = trial - {1'b0, dvs_q};
        ge    = (trial >= {1'b0, dvs_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            dvs_q  <= '0;
            quot_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            rem_q  <= '0;
            dvs_q  <= divisor;
            quot_q <= '0;
            idx_q  <= LAST_IDX;
        end else if (busy_q) begin
            rem_q         <= ge ? diff[W-1:0] : trial[W-1:0];
            quot_q[idx_q] <= ge;
            if (idx_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign quot = quot_q;

    assert_reload_starts_R9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    assert_timeout_held_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(quot));
endmodule

// File: rtl/rxidle_cnt.sv
module rxidle_cnt #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         byte_stb,
    input  logic         done_stb,
    input  logic         hold,
    input  logic         flag_clr,
    input  logic [W-1:0] tmo,
    output logic         stop_pulse,
    output logic         expired
);
    import rxidle_pkg::*;

    wd_state_e    st_q;
    logic [W-1:0] cnt_q;
    logic         stop_q;
    logic         flag_q;
    logic         fire;

    // Byte strobe outranks the compare; disable and end strobe outrank all
    always_comb begin
        fire = en && !done_stb && !byte_stb && !hold &&
               (st_q == WD_ARMED) && (cnt_q == tmo);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= WD_IDLE;
            cnt_q  <= '0;
            stop_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            stop_q <= fire;
            if (!en || done_stb) begin
                st_q  <= WD_IDLE;
                cnt_q <= '0;
            end else if (byte_stb) begin
                st_q  <= WD_ARMED;
                cnt_q <= '0;
            end else if (hold) begin
                cnt_q <= '0;
            end else if (fire) begin
                st_q  <= WD_IDLE;
                cnt_q <= '0;
            end else if (st_q == WD_ARMED) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fire) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign stop_pulse = stop_q;
    assign expired    = flag_q;

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse);

    assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |-> expired);

    assert_end_quiets_R6: assert property (@(posedge clk) disable iff (rst)
        done_stb |=> !stop_pulse);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !stop_pulse);

    assert_byte_restarts_R4: assert property (@(posedge clk) disable iff (rst)
        (en && byte_stb) |=> !stop_pulse);
endmodule

// File: rtl/rxidle_guard.sv
module rxidle_guard #(
    parameter int unsigned    CNT_W      = 32,
    parameter int unsigned    BAUD_W     = 32,
    parameter logic [31:0]    RESET_BAUD = 32'h01D7_E000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              guard_en,
    input  logic              rx_byte_stb,
    input  logic              rx_done_stb,
    input  logic              baud_wr,
    input  logic [BAUD_W-1:0] baud_word,
    input  logic              flag_clr,
    output logic              stop_rx_pulse,
    output logic              idle_expired,
    output logic [CNT_W-1:0]  timeout_ticks
);
    import rxidle_pkg::*;

    localparam logic [BAUD_W-1:0] BOOT_WORD = BAUD_W'(RESET_BAUD);

    logic              boot_q;
    logic              reload;
    logic [BAUD_W-1:0] word_sel;
    logic [CNT_W-1:0]  divisor;
    logic              div_busy;

    // One reload right after reset, from the parameter default
    always_ff @(posedge clk) begin
        if (rst) boot_q <= 1'b1;
        else     boot_q <= 1'b0;
    end

    always_comb begin
        reload   = baud_wr || boot_q;
        word_sel = boot_q ? BOOT_WORD : baud_word;
        divisor  = CNT_W'(word_sel / BAUD_W'(BAUD_SCALE));
    end

    rxidle_div #(.W(CNT_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start   (reload),
        .divisor (divisor),
        .busy    (div_busy),
        .quot    (timeout_ticks)
    );

    rxidle_cnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .en         (guard_en),
        .byte_stb   (rx_byte_stb),
        .done_stb   (rx_done_stb),
        .hold       (reload || div_busy),
        .flag_clr   (flag_clr),
        .tmo        (timeout_ticks),
        .stop_pulse (stop_rx_pulse),
        .expired    (idle_expired)
    );
endmodule

// File: tb/test_rxidle_guard.sv
`timescale 1ns/1ps
module test_rxidle_guard;
    localparam int CW = 32;
    localparam int NV = 5;
    // d*40 + offset below 40, so truncation of the /40 is exercised
    localparam logic [31:0] VEC_BAUD [NV] = '{
        32'd4294967280,  // d=107374182 -> T=20
        32'd4000000039,  // d=100000000 -> T=21
        32'd2321603933,  // d=58040098  -> T=37
        32'd1342177285,  // d=33554432  -> T=64
        32'd25           // d=0 -> saturated
    };

    logic clk = 1'b0;
    logic rst, guard_en, rx_byte_stb, rx_done_stb, baud_wr, flag_clr;
    logic [31:0] baud_word;
    logic stop_rx_pulse, idle_expired;
    logic [31:0] timeout_ticks;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rxidle_guard i_rxidle_guard (
        .clk(clk), .rst(rst), .guard_en(guard_en), .rx_byte_stb(rx_byte_stb),
        .rx_done_stb(rx_done_stb), .baud_wr(baud_wr), .baud_word(baud_word),
        .flag_clr(flag_clr), .stop_rx_pulse(stop_rx_pulse),
        .idle_expired(idle_expired), .timeout_ticks(timeout_ticks)
    );

    function automatic logic [31:0] exp_tmo(input logic [31:0] b);
        logic [31:0] d;
        d = b / 32'd40;
        return (d == 0) ? 32'hFFFF_FFFF : (32'h8000_0000 / d);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_byte();
        rx_byte_stb = 1'b1;
        @(negedge clk);
        rx_byte_stb = 1'b0;
    endtask

    task automatic write_baud(input logic [31:0] w);
        baud_word = w;
        baud_wr = 1'b1;
        @(negedge clk);
        baud_wr = 1'b0;
    endtask

    // Edge index of the first stop pulse (0 if none) and pulse count
    task automatic watch(input int limit, output int first, output int npulse);
        first = 0;
        npulse = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (stop_rx_pulse) begin
                npulse++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int first, np;
        logic [31:0] t;
        rst = 1'b1; guard_en = 1'b0; rx_byte_stb = 1'b0; rx_done_stb = 1'b0;
        baud_wr = 1'b0; flag_clr = 1'b0; baud_word = '0;
        ticks(3);
        chk(stop_rx_pulse == 1'b0, "R1 stop", stop_rx_pulse, 0);
        chk(idle_expired == 1'b0, "R1 flag", idle_expired, 0);
        rst = 1'b0;
        guard_en = 1'b1;
        ticks(40);
        chk(timeout_ticks == exp_tmo(32'h01D7_E000), "R2 boot timeout", timeout_ticks, exp_tmo(32'h01D7_E000));
        // R5: no byte since reset -> never fires
        watch(3000, first, np);
        chk(np == 0, "R5 idle without byte", np, 0);

        // Vector table walk: R2, R3, R10, R8
        for (int v = 0; v < NV; v++) begin
            t = exp_tmo(VEC_BAUD[v]);
            write_baud(VEC_BAUD[v]);
            ticks(CW + 4);
            chk(timeout_ticks == t, "R2 timeout formula", timeout_ticks, t);
            pulse_byte();
            if (t < 1000) begin
                watch(int'(t) + 30, first, np);
                chk(first == int'(t) + 1, "R3 pulse edge", first, int'(t) + 1);
                chk(np == 1, "R10 single pulse", np, 1);
                chk(idle_expired == 1'b1, "R8 flag set", idle_expired, 1);
                flag_clr = 1'b1;
                @(negedge clk);
                flag_clr = 1'b0;
                chk(idle_expired == 1'b0, "R8 flag cleared", idle_expired, 0);
            end else begin
                watch(200, first, np);
                chk(np == 0, "R2 saturated timeout quiet", np, 0);
                rx_done_stb = 1'b1;
                @(negedge clk);
                rx_done_stb = 1'b0;
            end
        end

        // Use T=20 for the directed cases
        write_baud(VEC_BAUD[0]);
        ticks(CW + 4);
        t = exp_tmo(VEC_BAUD[0]);

        // R8: flag sticky without clear
        pulse_byte();
        watch(int'(t) + 1, first, np);
        ticks(25);
        chk(idle_expired == 1'b1, "R8 flag sticky", idle_expired, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;

        // R4: restart just before expiry
        pulse_byte();
        watch(int'(t) - 5, first, np);
        chk(np == 0, "R4 no early pulse", np, 0);
        pulse_byte();
        watch(int'(t) + 10, first, np);
        chk(first == int'(t) + 1, "R4 restart edge", first, int'(t) + 1);

        // R6: end strobe disarms
        pulse_byte();
        ticks(5);
        rx_done_stb = 1'b1;
        @(negedge clk);
        rx_done_stb = 1'b0;
        watch(int'(t) + 40, first, np);
        chk(np == 0, "R6 end strobe quiet", np, 0);

        // R7: disabled ignores bytes
        guard_en = 1'b0;
        pulse_byte();
        watch(int'(t) + 40, first, np);
        chk(np == 0, "R7 disabled quiet", np, 0);
        guard_en = 1'b1;
        // R7: disabling mid-count disarms
        pulse_byte();
        ticks(5);
        guard_en = 1'b0;
        @(negedge clk);
        guard_en = 1'b1;
        watch(int'(t) + 40, first, np);
        chk(np == 0, "R7 disable mid-count", np, 0);

        // R9: reload mid-count holds and restarts the count
        pulse_byte();
        ticks(9);
        write_baud(VEC_BAUD[0]);
        watch(CW + int'(t) + 20, first, np);
        chk(first == CW + int'(t) + 1, "R9 reload delay", first, CW + int'(t) + 1);

        // R8: pulse and clear in the same cycle -> set wins
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        pulse_byte();
        ticks(int'(t));
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(stop_rx_pulse == 1'b1, "R3 pulse at T+1", stop_rx_pulse, 1);
        chk(idle_expired == 1'b1, "R8 set beats clear", idle_expired, 1);

        // R1: reset returns to quiet state
        rst = 1'b1;
        @(negedge clk);
        chk(idle_expired == 1'b0, "R1 flag after reset", idle_expired, 0);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule